// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the oversampling strobe of a serial port from its module clock. Software sets a 13-bit whole divisor and a 5-bit fraction counted in thirty-seconds. The block then emits a one-cycle sample strobe whose average spacing is the whole divisor plus the fraction, in module-clock cycles. It also emits a bit strobe on every sixteenth sample strobe. The resulting bit rate is the module clock divided by sixteen times (whole + fraction/32). The fastest setting gives a bit rate of one sixteenth of the module clock.

The fraction is spread over time by a 5-bit phase accumulator. The fraction is added to it once per sample period. A period in which the sum overflows is one module-clock cycle longer. Over any 32 consecutive periods this adds exactly as many cycles as the fraction value.

The divisor is set through three byte registers. Software normally writes them only while the serial engine is idle. Writes to the upper whole byte and to the control byte are staged. All three values take effect together on the write of the lower whole byte. That write also restarts every counter, so a new rate never runs with a half-updated divisor.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `tick_o` and `bit_en_o` stay low and every register reads back 0.
- R2: Register addresses are 0 = upper whole byte, 1 = lower whole byte, 2 = control byte and 3 = unused.
  - Only bits [4:0] of address 0 are stored; its bits [7:5] read as 0.
  - Address 1 stores all 8 bits and supplies divisor bits [7:0]. Address 0 bits [4:0] supply divisor bits [12:8].
  - Address 2 stores all 8 bits; bits [4:0] are the fraction F.
  - Writes to address 3 are dropped, and address 3 reads 0.
  - `rd_data` shows the register chosen by `rd_addr` one clock edge later.
- R3: With F = 0 and whole divisor D > 0, `tick_o` pulses for one cycle every D cycles.
  - The first pulse is D cycles after the clock edge that captured the lower-byte write.
- R4: With fraction F, the length of sample period k (k = 0, 1, ...) counted from a reload is D + c_k.
  - c_k is the carry out of the 5-bit sum acc_k + F.
  - acc_0 = 0, and acc_{k+1} = (acc_k + F) mod 32.
  - Therefore any 32 periods from a reload last 32*D + F cycles.
- R5: Writes to address 0 or address 2 do not change the tick timing until address 1 is written.
- R6: Control bits [7:5] have no effect on the tick timing.
- R7: While the active whole divisor is 0, no tick or bit strobe is produced.
- R8: `bit_en_o` pulses together with every sixteenth `tick_o` pulse counted from a reload, and never without `tick_o`.
- R9: A write to address 1 restarts the generator.
  - Both strobes are low in the cycle after that write.
  - The period counter, the phase accumulator and the sixteen-tick count all restart from zero.
- R10: The extreme settings work.
  - D = 1 with F = 0 gives a tick every cycle.
  - D = 8191 with F = 31 gives first periods of 8191 and 8192 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| tick_o | output | 1 | 16x sample-enable pulse |
| bit_en_o | output | 1 | Bit-rate enable pulse |

## Verification
Two situations are hard to reach from the ports. One is a staged write of the upper byte or the fraction while the old divisor is still running. The bench reaches it by first starting a known rate. It then writes address 0 and address 2 mid-stream, discards the partial interval, and checks that later intervals keep the old length. Only after that does it write the lower byte and look for the new dithered pattern.

The other is the fraction carry at its widest. The bench reaches it by loading the largest whole divisor together with fraction 31. It then measures the first two periods, which must differ by exactly one cycle.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_HI   = 2'd0,
    ADR_LO   = 2'd1,
    ADR_CTL  = 2'd2,
    ADR_NONE = 2'd3
  } fbg_addr_e;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
#(
  parameter int unsigned INT_W  = 13,
  parameter int unsigned FRAC_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [REG_W-1:0]    rd_data,
  output logic [INT_W-1:0]    act_sbr,
  output logic [FRAC_W-1:0]   act_frac,
  output logic                reload
);
  localparam int unsigned HI_W = INT_W - REG_W;

  logic [HI_W-1:0]  hi_q;
  logic [REG_W-1:0] lo_q;
  logic [REG_W-1:0] ctl_q;

  // the lower-byte write commits the staged divisor and restarts counters
  assign reload = wr_en && (wr_addr == ADR_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      ctl_q    <= '0;
      act_sbr  <= '0;
      act_frac <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_HI:  hi_q  <= wr_data[HI_W-1:0];
        ADR_CTL: ctl_q <= wr_data;
        ADR_LO: begin
          lo_q     <= wr_data;
          act_sbr  <= {hi_q, wr_data};
          act_frac <= ctl_q[FRAC_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADR_HI:  rd_data <= {{(REG_W-HI_W){1'b0}}, hi_q};
        ADR_LO:  rd_data <= lo_q;
        ADR_CTL: rd_data <= ctl_q;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fbg_period.sv
module fbg_period #(
  parameter int unsigned INT_W  = 13,
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic [INT_W-1:0]  sbr,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick_hit,
  output logic              tick_q
);
  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   phase_sum;
  logic [INT_W:0]    len_w;
  logic [INT_W:0]    last_w;
  logic              running;

  // period length is sbr, stretched by one when the phase sum overflows
  assign phase_sum = {1'b0, acc_q} + {1'b0, frac};
  assign len_w     = {1'b0, sbr} + {{INT_W{1'b0}}, phase_sum[FRAC_W]};
  assign last_w    = len_w - {{INT_W{1'b0}}, 1'b1};
  assign running   = (sbr != '0);
  assign tick_hit  = running && ({1'b0, cnt_q} == last_w);

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_hit;
      if (tick_hit) begin
        cnt_q <= '0;
        acc_q <= phase_sum[FRAC_W-1:0];
      end else if (running) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbg_bitdiv.sv
module fbg_bitdiv #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic tick_hit,
  output logic bit_q
);
  localparam int unsigned SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [SUB_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      sub_q <= '0;
      bit_q <= 1'b0;
    end else begin
      bit_q <= tick_hit && (sub_q == SUB_LAST);
      if (tick_hit) begin
        if (sub_q == SUB_LAST) sub_q <= '0;
        else                   sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned INT_W  = 13,
  parameter int unsigned FRAC_W = 5,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              tick_o,
  output logic              bit_en_o
);
  logic [INT_W-1:0]  act_sbr;
  logic [FRAC_W-1:0] act_frac;
  logic              reload;
  logic              tick_hit;

  fbg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .act_sbr  (act_sbr),
    .act_frac (act_frac),
    .reload   (reload)
  );

  fbg_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) period_i (
    .clk      (clk),
    .rst      (rst),
    .reload   (reload),
    .sbr      (act_sbr),
    .frac     (act_frac),
    .tick_hit (tick_hit),
    .tick_q   (tick_o)
  );

  fbg_bitdiv #(.OVS(OVS)) bitdiv_i (
    .clk      (clk),
    .rst      (rst),
    .reload   (reload),
    .tick_hit (tick_hit),
    .bit_q    (bit_en_o)
  );
endmodule

// File: rtl/fbg_chk.sv
module fbg_chk #(
  parameter int unsigned INT_W  = 13,
  parameter int unsigned FRAC_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic              tick_o,
  input logic              bit_en_o,
  input logic [INT_W-1:0]  act_sbr,
  input logic [FRAC_W-1:0] act_frac
);
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick_o && act_sbr > 1) |=> !tick_o);                          // R3

  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != 2'd1) |=> ($stable(act_sbr) && $stable(act_frac))); // R5

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (act_sbr == '0) |-> (!tick_o && !bit_en_o));                    // R7

  AST_BIT_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_en_o |-> tick_o);                                           // R8

  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> (!tick_o && !bit_en_o));         // R9
endmodule

bind frac_baud_gen fbg_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .tick_o   (tick_o),
  .bit_en_o (bit_en_o),
  .act_sbr  (act_sbr),
  .act_frac (act_frac)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       tick_o;
  logic       bit_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int gaps [0:63];
  int got;
  int first_bit;
  int bit_cnt;
  int bit_alone;

  always #2.5 clk = ~clk;

  frac_baud_gen dut_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .tick_o   (tick_o),
    .bit_en_o (bit_en_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // fraction model: length of period k after a reload
  function automatic int exp_gap(input int d, input int f, input int k);
    int acc = 0;
    for (int i = 0; i < k; i++) acc = (acc + f) % 32;
    return d + (((acc + f) >= 32) ? 1 : 0);
  endfunction

  task automatic collect(input int n, input int limit);
    int since = 0;
    int cyc = 0;
    for (int i = 0; i < 64; i++) gaps[i] = -1;
    got = 0; first_bit = -1; bit_cnt = 0; bit_alone = 0;
    while (got < n && cyc < limit) begin
      @(negedge clk);
      cyc++; since++;
      if (bit_en_o && !tick_o) bit_alone++;
      if (tick_o) begin
        if (got < 64) gaps[got] = since;
        if (bit_en_o) begin
          bit_cnt++;
          if (first_bit < 0) first_bit = got + 1;
        end
        got++;
        since = 0;
      end
    end
  endtask

  task automatic t_reset();
    int v;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!tick_o && !bit_en_o, "R1 strobes low after reset", int'(tick_o) + int'(bit_en_o), 0);
    end
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1 register reset value", v, 0);
    end
  endtask

  task automatic t_regs();
    int v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check(v == 8'h1F, "R2 upper byte keeps [4:0]", v, 8'h1F);
    wr(2'd2, 8'hE3); rd(2'd2, v); check(v == 8'hE3, "R2 control byte readback", v, 8'hE3);
    wr(2'd3, 8'h55); rd(2'd3, v); check(v == 0, "R2 unused address", v, 0);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    wr(2'd1, 8'h5A); rd(2'd1, v); check(v == 8'h5A, "R2 lower byte readback", v, 8'h5A);
  endtask

  task automatic t_int();
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'd4);
    collect(8, 200);
    for (int i = 0; i < 8; i++)
      check(gaps[i] == 4, "R3 integer period", gaps[i], 4);
  endtask

  task automatic t_frac();
    int sum = 0;
    wr(2'd2, 8'd8); wr(2'd1, 8'd3);
    collect(32, 400);
    for (int i = 0; i < 32; i++) begin
      check(gaps[i] == exp_gap(3, 8, i), "R4 dithered period", gaps[i], exp_gap(3, 8, i));
      sum += gaps[i];
    end
    check(sum == 32 * 3 + 8, "R4 32-period total", sum, 104);
  endtask

  task automatic t_hold();
    wr(2'd2, 8'd0); wr(2'd1, 8'd4);
    wr(2'd2, 8'd16); wr(2'd0, 8'd1);
    collect(6, 200);
    for (int i = 1; i < 6; i++)
      check(gaps[i] == 4, "R5 staged writes held", gaps[i], 4);
    wr(2'd0, 8'd0); wr(2'd1, 8'd4);
    collect(4, 200);
    for (int i = 0; i < 4; i++)
      check(gaps[i] == exp_gap(4, 16, i), "R5 staged fraction applied", gaps[i], exp_gap(4, 16, i));
    wr(2'd0, 8'd1); wr(2'd2, 8'd0); wr(2'd1, 8'd0);
    collect(2, 1000);
    check(gaps[0] == 256 && gaps[1] == 256, "R5 staged upper byte applied", gaps[0], 256);
  endtask

  task automatic t_upper();
    wr(2'd0, 8'd0); wr(2'd2, 8'hE0); wr(2'd1, 8'd5);
    collect(6, 200);
    for (int i = 0; i < 6; i++)
      check(gaps[i] == 5, "R6 upper control bits ignored", gaps[i], 5);
    wr(2'd2, 8'hE4); wr(2'd1, 8'd5);
    collect(8, 200);
    for (int i = 0; i < 8; i++)
      check(gaps[i] == exp_gap(5, 4, i), "R6 only [4:0] is fraction", gaps[i], exp_gap(5, 4, i));
  endtask

  task automatic t_zero();
    wr(2'd2, 8'd7); wr(2'd0, 8'd0); wr(2'd1, 8'd0);
    collect(1, 300);
    check(got == 0, "R7 zero divisor stops ticks", got, 0);
    check(bit_cnt == 0 && bit_alone == 0, "R7 zero divisor no bit strobe", bit_cnt + bit_alone, 0);
  endtask

  task automatic t_bit();
    wr(2'd2, 8'd0); wr(2'd1, 8'd2);
    collect(40, 400);
    check(first_bit == 16, "R8 first bit strobe on 16th tick", first_bit, 16);
    check(bit_cnt == 2, "R8 bit strobes in 40 ticks", bit_cnt, 2);
    check(bit_alone == 0, "R8 bit strobe without tick", bit_alone, 0);
  endtask

  task automatic t_restart();
    wr(2'd1, 8'd2);
    collect(5, 100);
    wr(2'd1, 8'd2);
    check(!tick_o && !bit_en_o, "R9 strobes quiet after reload", int'(tick_o) + int'(bit_en_o), 0);
    collect(20, 200);
    check(gaps[0] == 2, "R9 period restarts", gaps[0], 2);
    check(first_bit == 16, "R9 sixteen-count restarts", first_bit, 16);
    wr(2'd2, 8'd8); wr(2'd1, 8'd3);
    collect(5, 200);
    collect(4, 200);
    wr(2'd1, 8'd3);
    collect(4, 200);
    for (int i = 0; i < 4; i++)
      check(gaps[i] == exp_gap(3, 8, i), "R9 accumulator restarts", gaps[i], exp_gap(3, 8, i));
  endtask

  task automatic t_ext();
    wr(2'd2, 8'd0); wr(2'd0, 8'd0); wr(2'd1, 8'd1);
    collect(32, 100);
    for (int i = 0; i < 32; i++)
      check(gaps[i] == 1, "R10 divisor 1 every cycle", gaps[i], 1);
    check(first_bit == 16, "R10 divisor 1 bit strobe", first_bit, 16);
    wr(2'd0, 8'h1F); wr(2'd2, 8'd31); wr(2'd1, 8'hFF);
    collect(2, 20000);
    check(gaps[0] == 8191, "R10 max divisor first period", gaps[0], 8191);
    check(gaps[1] == 8192, "R10 max divisor stretched period", gaps[1], 8192);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_int();
    t_frac();
    t_hold();
    t_upper();
    t_zero();
    t_bit();
    t_restart();
    t_ext();
    finish_run();
  end
endmodule